// File: doc/BRIEF.md
# Single-to-Double Float Widener

This block widens a 32-bit single-precision floating-point word into the 64-bit double-precision register layout. A request is made by pulsing `start_i` with the word on `word_i`. The result appears on `result_o` together with a one-cycle `done_o` pulse, and it stays there until the next conversion completes.

Normal numbers, infinities, NaNs and zeros are widened by a fixed bit mapping in a single cycle. For normal numbers, the exponent is rebiased by copying the exponent MSB and repeating its inverse three times, so no adder is needed. A denormal single has no implicit leading one. It is normalised by a loop that shifts left one place per cycle and lowers the exponent by one each step. During the loop `busy_o` is high, and any new start is ignored.

Rounding, exception flags and status updates are outside this block.

Top module: `fp_s2d_widen`

## Requirements
- R1: Field layout (bit 31 is the MSB). The input has sign at bit 31, exponent at [30:23] and fraction at [22:0]. The output has sign at bit 63, exponent at [62:52] and fraction at [51:0].
- R2: For an input exponent from 1 to 254, the output sign equals the input sign. The output exponent equals the input exponent plus 896. The output fraction is the input fraction followed by 29 zero bits.
- R3: For an input exponent of 255 (infinity or NaN), the output exponent is 0x7FF. The fraction is the input fraction followed by 29 zeros, and the sign is kept.
- R4: When input bits [30:0] are all zero, the output is the input sign followed by 63 zero bits.
- R5: Denormal inputs (exponent 0, non-zero fraction) are normalised. Let p be the position of the highest set fraction bit and n = 23 - p. The output exponent is 897 - n. The output fraction is the input fraction shifted left by n, keeping the low 23 bits, followed by 29 zeros. The sign is kept.
- R6: For a non-denormal input, `done_o` is high in the cycle after the start cycle and `busy_o` stays low. Starts on consecutive cycles each produce a result on the following cycle.
- R7: For a denormal input, `busy_o` is high from the cycle after start until the result. `done_o` rises n+1 cycles after the start cycle, with `busy_o` low in that cycle.
- R8: A start while `busy_o` is high has no effect. The pending denormal result and its timing are unchanged, and no extra `done_o` pulse occurs.
- R9: After reset, `busy_o` and `done_o` are 0 and `result_o` is all zeros. `done_o` is a one-cycle pulse, and `result_o` holds its value after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled when not busy |
| word_i | input | 32 | Single-precision operand |
| busy_o | output | 1 | Denormal normalisation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 64 | Double-precision result, held until next completion |

## Verification
The assertions assume the input is stable only at the sampling edge. They assume a start during the loop may carry any word and must leave no trace. They also assume a loop never begins with the leading bit already set, because the classifier admits only non-zero denormal fractions.

The stimulus keeps within these assumptions. It drives starts only at the falling edge and holds start for exactly the cycles it intends. It issues the deliberately ignored start only while busy is seen high. All denormal fractions it uses are non-zero, including the single-bit extremes at both ends of the fraction.

// File: rtl/fp_widen_pkg.sv
package fp_widen_pkg;
  localparam int SP_W       = 32;
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int DP_W       = 64;
  localparam int DP_EXP_W   = 11;
  localparam int DP_FRAC_W  = 52;
  localparam int PAD_W      = DP_FRAC_W - SP_FRAC_W;
  localparam int REP_W      = DP_EXP_W - SP_EXP_W;
  localparam int CNT_W      = $clog2(SP_FRAC_W + 1);
  // 1023 - 126: exponent field of an unshifted denormal
  localparam int DENORM_EXP = (1 << (DP_EXP_W - 1)) - 1 - ((1 << (SP_EXP_W - 1)) - 2);

  typedef enum logic [1:0] {
    CLS_NORMAL  = 2'd0,
    CLS_SPECIAL = 2'd1,
    CLS_DENORM  = 2'd2
  } cls_e;
endpackage

// File: rtl/fp_widen_classify.sv
module fp_widen_classify
  import fp_widen_pkg::*;
(
  input  logic [SP_W-1:0] word_i,
  output cls_e            cls_o
);
  logic [SP_EXP_W-1:0]  exp_w;
  logic [SP_FRAC_W-1:0] frac_w;

  assign exp_w  = word_i[SP_W-2 -: SP_EXP_W];
  assign frac_w = word_i[SP_FRAC_W-1:0];

  always_comb begin
    if (&exp_w || ~|word_i[SP_W-2:0]) cls_o = CLS_SPECIAL;
    else if (~|exp_w)                 cls_o = CLS_DENORM;
    else                              cls_o = CLS_NORMAL;
  end
endmodule

// File: rtl/fp_widen_map.sv
module fp_widen_map
  import fp_widen_pkg::*;
(
  input  logic [SP_W-1:0] word_i,
  input  logic            special_i,
  output logic [DP_W-1:0] dp_o
);
  logic rep_bit;

  // exponent rebias by replication: normal takes inverted exp MSB
  assign rep_bit = special_i ? word_i[SP_W-2] : ~word_i[SP_W-2];
  assign dp_o = {word_i[SP_W-1], word_i[SP_W-2], {REP_W{rep_bit}},
                 word_i[SP_W-3:0], {PAD_W{1'b0}}};
endmodule

// File: rtl/fp_widen_norm.sv
module fp_widen_norm
  import fp_widen_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 sign_i,
  input  logic [SP_FRAC_W-1:0] frac_i,
  output logic                 busy_o,
  output logic                 fin_o,
  output logic [DP_W-1:0]      res_o
);
  logic                 busy_q, sign_q;
  logic [SP_FRAC_W:0]   acc_q, acc_nxt;
  logic [CNT_W-1:0]     cnt_q, cnt_nxt;
  logic [DP_EXP_W-1:0]  exp_nxt;

  assign acc_nxt = acc_q << 1;
  assign cnt_nxt = cnt_q + 1'b1;
  assign exp_nxt = DP_EXP_W'(DENORM_EXP) - DP_EXP_W'(cnt_nxt);
  assign fin_o   = busy_q && acc_nxt[SP_FRAC_W];
  assign busy_o  = busy_q;
  assign res_o   = {sign_q, exp_nxt, acc_nxt[SP_FRAC_W-1:0], {PAD_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sign_q <= 1'b0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      sign_q <= sign_i;
      acc_q  <= {1'b0, frac_i};
      cnt_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_nxt;
      if (acc_nxt[SP_FRAC_W]) busy_q <= 1'b0;
    end
  end

  a_r7_lead_clear_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !acc_q[SP_FRAC_W]);
  a_r7_shift_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(SP_FRAC_W)));
endmodule

// File: rtl/fp_s2d_widen.sv
module fp_s2d_widen
  import fp_widen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [SP_W-1:0] word_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DP_W-1:0] result_o
);
  cls_e            cls;
  logic [DP_W-1:0] map_res, norm_res;
  logic            norm_busy, norm_fin, accept, load_dn;
  logic            done_q;
  logic [DP_W-1:0] res_q;

  fp_widen_classify u_cls (.word_i(word_i), .cls_o(cls));

  fp_widen_map u_map (
    .word_i   (word_i),
    .special_i(cls == CLS_SPECIAL),
    .dp_o     (map_res)
  );

  assign accept  = start_i && !norm_busy;
  assign load_dn = accept && (cls == CLS_DENORM);

  fp_widen_norm u_norm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_dn),
    .sign_i(word_i[SP_W-1]),
    .frac_i(word_i[SP_FRAC_W-1:0]),
    .busy_o(norm_busy),
    .fin_o (norm_fin),
    .res_o (norm_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else if (norm_fin) begin
      done_q <= 1'b1;
      res_q  <= norm_res;
    end else if (accept && !load_dn) begin
      done_q <= 1'b1;
      res_q  <= map_res;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o   = norm_busy;
  assign done_o   = done_q;
  assign result_o = res_q;

  a_r6_fast_path_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cls != CLS_DENORM) |=> (done_o && !busy_o));
  a_r7_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r8_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r5_denorm_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |->
      (result_o[DP_W-2 -: DP_EXP_W] <= DP_EXP_W'(DENORM_EXP - 1) &&
       result_o[DP_W-2 -: DP_EXP_W] >= DP_EXP_W'(DENORM_EXP - SP_FRAC_W)));
endmodule

// File: tb/tb_fp_s2d_widen.sv
module tb_fp_s2d_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] word = '0;
  logic        busy, done;
  logic [63:0] result;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  fp_s2d_widen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  localparam int NV = 14;
  localparam logic [31:0] VEC [NV] = '{
    32'h3F80_0000, 32'hC000_0000, 32'h7F7F_FFFF, 32'h0080_0000,
    32'h0000_0000, 32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'h7FC0_0001, 32'h0040_0000, 32'h807F_FFFF, 32'h0000_0300,
    32'h0000_0001, 32'h8000_0002};
  localparam int VLAT [NV] = '{1,1,1,1, 1,1,1,1, 1, 2,2,15,24,23};

  function automatic int shifts(input logic [22:0] f);
    int p = 0;
    for (int i = 0; i < 23; i++) if (f[i]) p = i;
    return 23 - p;
  endfunction

  function automatic logic [63:0] model(input logic [31:0] w);
    logic [7:0]  e = w[30:23];
    logic [22:0] f = w[22:0];
    logic [23:0] sh;
    int n;
    if (e == 8'hFF) return {w[31], 11'h7FF, f, 29'b0};
    if (e != 0)     return {w[31], 11'(e) + 11'd896, f, 29'b0};
    if (f == 0)     return {w[31], 63'b0};
    n  = shifts(f);
    sh = 24'(f) << n;
    return {w[31], 11'd897 - 11'(n), sh[22:0], 29'b0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one start cycle and measure cycles until done
  task automatic convert(input logic [31:0] w, output int lat, output bit busy_seen);
    @(negedge clk);
    start = 1'b1; word = w;
    @(negedge clk);
    start = 1'b0; word = '0;
    lat = 1; busy_seen = busy;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (busy) busy_seen = 1'b1;
    end
  endtask

  initial begin
    int lat;
    bit bs;
    #20;
    @(negedge clk);
    // R9 reset state
    check("R9 reset busy", 64'(busy), 64'd0);
    check("R9 reset done", 64'(done), 64'd0);
    check("R9 reset result", result, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      convert(VEC[i], lat, bs);
      check("R1/R2/R3/R4/R5 value", result, model(VEC[i]));
      check("R6/R7 latency", 64'(lat), 64'(VLAT[i]));
      check("R6/R7 busy seen", 64'(bs), 64'(VLAT[i] > 1));
    end

    // directed literal values
    convert(32'h3F80_0000, lat, bs);
    check("R2 one", result, 64'h3FF0_0000_0000_0000);
    convert(32'h0040_0000, lat, bs);
    check("R5 largest denormal bit", result, 64'h3800_0000_0000_0000);
    convert(32'h0000_0001, lat, bs);
    check("R5 smallest denormal", result, 64'h36A0_0000_0000_0000);
    convert(32'h7F80_0000, lat, bs);
    check("R3 infinity", result, 64'h7FF0_0000_0000_0000);

    // R9 done is a pulse and result holds
    @(negedge clk);
    check("R9 done pulse", 64'(done), 64'd0);
    check("R9 result held", result, 64'h7FF0_0000_0000_0000);

    // R6 back-to-back starts
    @(negedge clk);
    start = 1'b1; word = 32'h3F80_0000;
    @(negedge clk);
    check("R6 first done", 64'(done), 64'd1);
    check("R6 first value", result, 64'h3FF0_0000_0000_0000);
    word = 32'hC000_0000;
    @(negedge clk);
    start = 1'b0;
    check("R6 second done", 64'(done), 64'd1);
    check("R6 second value", result, model(32'hC000_0000));

    // R8 start while busy is ignored
    @(negedge clk);
    start = 1'b1; word = 32'h0000_0001;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (lat == 3 && busy) begin start = 1'b1; word = 32'h3F80_0000; end
      else begin start = 1'b0; word = '0; end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check("R8 latency unchanged", 64'(lat), 64'd24);
    check("R8 pending value", result, 64'h36A0_0000_0000_0000);
    @(negedge clk);
    check("R8 no extra done", 64'(done), 64'd0);
    check("R8 result kept", result, 64'h36A0_0000_0000_0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule